// File: doc/BRIEF.md
# Indexed Controller Register Port

This block is the byte-wide register port of a disc data controller. A host first loads a 4-bit register index. Each later data strobe then acts on the register that the index selects, and the index moves forward by itself. Software can therefore walk a whole group of registers with a run of back-to-back strobes. The same index selects different registers on the read side and the write side.

The block holds these registers:
- the interface control byte and the interface status byte,
- four 16-bit registers, each loaded a byte at a time: transfer byte count, data address, write address and block pointer,
- two control bytes.

Stored values go out as plain outputs to the neighbouring transfer and decoder blocks. The header banks and status bytes come in from those blocks as side-band inputs, and so do updates to the interface status. A write to the trigger, acknowledge or reset slot gives a one-cycle command pulse.

Top module: `ctl_regport`

## Requirements
- R1: After reset the index is 0, `rdata` is 0x00, every stored control output is zero, and the interface status (read at index 1) is 0xFF.
- R2: When no data strobe is active, `idx_ld` loads `idx_val` into the index. The next `rdata` then shows the register that the read side maps to that index.
- R3: A write at index n, for n from 1 to 14, sets the index to n+1. A write at index 15 sets the index to 0.
- R4: A read strobe at index n, for n from 1 to 14, sets the index to n+1. A read at index 15 returns status byte 3 and sets the index to 0.
- R5: Write slots:
  - 1 loads `if_ctrl`.
  - 2/3 load `byte_cnt` bits 7:0 / 15:8.
  - 4/5 load `data_addr` bits 7:0 / 15:8.
  - 8/9 load `wr_addr` bits 7:0 / 15:8.
  - 10 loads `ctl0` and 11 loads `ctl1`.
  - 12/13 load `blk_ptr` bits 7:0 / 15:8.
  - 14 is accepted and stores nothing.
- R6: Read slots:
  - 1 returns the interface status, which holds the last value presented on `ifst_val` while `ifst_ld` was high.
  - 2/3 return the byte count low/high.
  - 8/9 return the block pointer low/high.
  - 10/11 return the write address low/high.
  - 12, 14 and 15 return status bytes 0, 2 and 3, which are `stat_bytes` bits 7:0, 23:16 and 31:24.
- R7: A low-byte write changes only bits 7:0 of its 16-bit register. A high-byte write changes only bits 15:8.
- R8: A read at index 13 returns 0x00, whatever is on `stat_bytes` bits 15:8.
- R9: Read slots 4 to 7 return header byte k = index-4, taken from bits 8k+7:8k. The bytes come from `hdr_bank1` when `ctl1` bit 0 is 1 and from `hdr_bank0` when it is 0.
- R10: At index 0, `rdata` is 0x00. A read or a write there changes no register and leaves the index at 0.
- R11: A write strobe takes priority over `idx_ld` and over `rd_stb` in the same cycle. The write is carried out, the index advances as for a write, and the load and the read are ignored.
- R12: In the cycle after a write at index 6, 7 or 15, `xfer_trig`, `xfer_ack` or `ctl_reset` (in that order) is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_ld | input | 1 | Load the register index from `idx_val` |
| idx_val | input | 4 | Host index value |
| wr_stb | input | 1 | Data write strobe |
| rd_stb | input | 1 | Data read strobe; `rdata` is consumed in this cycle |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Byte at the current index in the read map |
| ifst_ld | input | 1 | Side-band load of the interface status |
| ifst_val | input | 8 | New interface status value |
| hdr_bank0 | input | 32 | Header bank 0, byte k at bits 8k+7:8k |
| hdr_bank1 | input | 32 | Header bank 1, byte k at bits 8k+7:8k |
| stat_bytes | input | 32 | Status bytes 0..3; byte 1 is never shown |
| if_ctrl | output | 8 | Interface control byte |
| byte_cnt | output | 16 | Transfer byte count |
| data_addr | output | 16 | Data address |
| wr_addr | output | 16 | Write address |
| blk_ptr | output | 16 | Block pointer |
| ctl0 | output | 8 | Control byte 0 |
| ctl1 | output | 8 | Control byte 1; bit 0 selects the header bank |
| xfer_trig | output | 1 | One-cycle pulse after a write at slot 6 |
| xfer_ack | output | 1 | One-cycle pulse after a write at slot 7 |
| ctl_reset | output | 1 | One-cycle pulse after a write at slot 15 |

## Verification
The hardest case to reach is a data strobe and an index load arriving in the same cycle. The stimulus places the index on a known slot and then raises the write strobe together with a load of a different index. Whether the load was dropped can only be seen from which read slot `rdata` shows next. A second case is the index sitting at 0 after the read-side wrap. That slot reads as zero just like status byte 1, so the stimulus follows the wrap with a write. It then shows that the write changed nothing, which proves the index is really 0.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int HDR_N  = 4;
  localparam int WIDE_N = 4;

  // write-side slot numbers
  localparam logic [IDX_W-1:0] W_IFCTRL = 4'd1;
  localparam logic [IDX_W-1:0] W_TRIG   = 4'd6;
  localparam logic [IDX_W-1:0] W_ACK    = 4'd7;
  localparam logic [IDX_W-1:0] W_CTL0   = 4'd10;
  localparam logic [IDX_W-1:0] W_CTL1   = 4'd11;
  localparam logic [IDX_W-1:0] W_RESET  = 4'd15;

  // index after an access: slot 0 stays put, the last slot wraps
  function automatic logic [IDX_W-1:0] step_index(input logic [IDX_W-1:0] cur);
    if (cur == '0 || cur == '1) return '0;
    return cur + 1'b1;
  endfunction

  // low-byte write slot of wide register k: count, data addr, write addr, pointer
  function automatic logic [IDX_W-1:0] wide_lo_slot(input int k);
    case (k)
      0:       return 4'd2;
      1:       return 4'd4;
      2:       return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

  // merge a byte into one half of a wide register
  function automatic logic [WIDE_W-1:0] merge_byte(input logic [WIDE_W-1:0] old,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    return hi ? {b, old[BYTE_W-1:0]} : {old[WIDE_W-1:BYTE_W], b};
  endfunction
endpackage

// File: rtl/regport_index.sv
module regport_index
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             wr_ev,
  input  logic             rd_ev,
  output logic [IDX_W-1:0] idx
);
  logic access;
  assign access = wr_ev | rd_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (access) idx <= step_index(idx);
    else if (ld)     idx <= ld_val;
  end

  a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && idx != 4'd0 && idx != 4'd15) |=> (idx == $past(idx) + 4'd1));
  a_r3_write_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && idx == 4'd15) |=> (idx == 4'd0));
  a_r4_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && idx == 4'd15) |=> (idx == 4'd0));
  a_r10_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (access && idx == 4'd0) |=> (idx == 4'd0));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !access) |=> (idx == $past(ld_val)));
endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ifst_ld,
  input  logic [BYTE_W-1:0] ifst_val,
  output logic [BYTE_W-1:0] ifstat,
  output logic [BYTE_W-1:0] if_ctrl,
  output logic [WIDE_W-1:0] wide [WIDE_N],
  output logic [BYTE_W-1:0] ctl0,
  output logic [BYTE_W-1:0] ctl1,
  output logic              xfer_trig,
  output logic              xfer_ack,
  output logic              ctl_reset
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifstat    <= '1;
      if_ctrl   <= '0;
      ctl0      <= '0;
      ctl1      <= '0;
      xfer_trig <= 1'b0;
      xfer_ack  <= 1'b0;
      ctl_reset <= 1'b0;
    end else begin
      if (ifst_ld)                    ifstat  <= ifst_val;
      if (wr_ev && idx == W_IFCTRL)   if_ctrl <= wdata;
      if (wr_ev && idx == W_CTL0)     ctl0    <= wdata;
      if (wr_ev && idx == W_CTL1)     ctl1    <= wdata;
      xfer_trig <= wr_ev && idx == W_TRIG;
      xfer_ack  <= wr_ev && idx == W_ACK;
      ctl_reset <= wr_ev && idx == W_RESET;
    end
  end

  for (genvar k = 0; k < WIDE_N; k++) begin : g_wide
    localparam logic [IDX_W-1:0] LO = wide_lo_slot(k);
    localparam logic [IDX_W-1:0] HI = LO + 4'd1;
    logic hit_lo, hit_hi;
    assign hit_lo = wr_ev && idx == LO;
    assign hit_hi = wr_ev && idx == HI;

    always_ff @(posedge clk) begin
      if (!rst_n)      wide[k] <= '0;
      else if (hit_lo) wide[k] <= merge_byte(wide[k], wdata, 1'b0);
      else if (hit_hi) wide[k] <= merge_byte(wide[k], wdata, 1'b1);
    end

    a_r7_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo |=> (wide[k][WIDE_W-1:BYTE_W] == $past(wide[k][WIDE_W-1:BYTE_W])));
    a_r7_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hi |=> (wide[k][BYTE_W-1:0] == $past(wide[k][BYTE_W-1:0])));
  end

  a_r12_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_trig |=> !xfer_trig);
  a_r12_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_trig, xfer_ack, ctl_reset}));
  a_r10_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && idx == 4'd0) |=> ($stable(if_ctrl) && $stable(ctl0) && $stable(ctl1)));
endmodule

// File: rtl/regport_rdmux.sv
module regport_rdmux
  import regport_pkg::*;
(
  input  logic [IDX_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       ifstat,
  input  logic [WIDE_W-1:0]       byte_cnt,
  input  logic [WIDE_W-1:0]       wr_addr,
  input  logic [WIDE_W-1:0]       blk_ptr,
  input  logic                    bank_sel,
  input  logic [HDR_N*BYTE_W-1:0] hdr_bank0,
  input  logic [HDR_N*BYTE_W-1:0] hdr_bank1,
  input  logic [4*BYTE_W-1:0]     stat_bytes,
  output logic [BYTE_W-1:0]       rdata
);
  logic [HDR_N*BYTE_W-1:0] hdr;
  logic [BYTE_W-1:0]       hdr_byte;
  assign hdr      = bank_sel ? hdr_bank1 : hdr_bank0;
  assign hdr_byte = hdr[idx[1:0]*BYTE_W +: BYTE_W];

  always_comb begin
    case (idx)
      4'd1:              rdata = ifstat;
      4'd2:              rdata = byte_cnt[BYTE_W-1:0];
      4'd3:              rdata = byte_cnt[WIDE_W-1:BYTE_W];
      4'd4, 4'd5,
      4'd6, 4'd7:        rdata = hdr_byte;
      4'd8:              rdata = blk_ptr[BYTE_W-1:0];
      4'd9:              rdata = blk_ptr[WIDE_W-1:BYTE_W];
      4'd10:             rdata = wr_addr[BYTE_W-1:0];
      4'd11:             rdata = wr_addr[WIDE_W-1:BYTE_W];
      4'd12:             rdata = stat_bytes[BYTE_W-1:0];
      4'd14:             rdata = stat_bytes[3*BYTE_W-1:2*BYTE_W];
      4'd15:             rdata = stat_bytes[4*BYTE_W-1:3*BYTE_W];
      default:           rdata = '0;
    endcase
  end

  always_comb begin
    if (idx == 4'd15) a_r4_last_is_stat3: assert (rdata == stat_bytes[31:24]);
  end
endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
  import regport_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    idx_ld,
  input  logic [IDX_W-1:0]        idx_val,
  input  logic                    wr_stb,
  input  logic                    rd_stb,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  input  logic                    ifst_ld,
  input  logic [BYTE_W-1:0]       ifst_val,
  input  logic [HDR_N*BYTE_W-1:0] hdr_bank0,
  input  logic [HDR_N*BYTE_W-1:0] hdr_bank1,
  input  logic [4*BYTE_W-1:0]     stat_bytes,
  output logic [BYTE_W-1:0]       if_ctrl,
  output logic [WIDE_W-1:0]       byte_cnt,
  output logic [WIDE_W-1:0]       data_addr,
  output logic [WIDE_W-1:0]       wr_addr,
  output logic [WIDE_W-1:0]       blk_ptr,
  output logic [BYTE_W-1:0]       ctl0,
  output logic [BYTE_W-1:0]       ctl1,
  output logic                    xfer_trig,
  output logic                    xfer_ack,
  output logic                    ctl_reset
);
  // named access events: a write wins over a read in the same cycle
  logic             wr_ev, rd_ev;
  logic [IDX_W-1:0] idx;
  logic [BYTE_W-1:0] ifstat;
  logic [WIDE_W-1:0] wide [WIDE_N];

  assign wr_ev = wr_stb;
  assign rd_ev = rd_stb & ~wr_stb;

  regport_index u_index (
    .clk(clk), .rst_n(rst_n), .ld(idx_ld), .ld_val(idx_val),
    .wr_ev(wr_ev), .rd_ev(rd_ev), .idx(idx)
  );

  regport_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .idx(idx), .wdata(wdata),
    .ifst_ld(ifst_ld), .ifst_val(ifst_val), .ifstat(ifstat),
    .if_ctrl(if_ctrl), .wide(wide), .ctl0(ctl0), .ctl1(ctl1),
    .xfer_trig(xfer_trig), .xfer_ack(xfer_ack), .ctl_reset(ctl_reset)
  );

  assign byte_cnt  = wide[0];
  assign data_addr = wide[1];
  assign wr_addr   = wide[2];
  assign blk_ptr   = wide[3];

  regport_rdmux u_rdmux (
    .idx(idx), .ifstat(ifstat), .byte_cnt(byte_cnt), .wr_addr(wr_addr),
    .blk_ptr(blk_ptr), .bank_sel(ctl1[0]), .hdr_bank0(hdr_bank0),
    .hdr_bank1(hdr_bank1), .stat_bytes(stat_bytes), .rdata(rdata)
  );

  a_r11_write_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && idx_ld && idx != 4'd0 && idx != 4'd15) |=> (idx == $past(idx) + 4'd1));
  a_r8_stat1_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 4'd13) |-> (rdata == 8'h00));
endmodule

// File: tb/test_ctl_regport.sv
`timescale 1ns/1ps
module test_ctl_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic idx_ld = 0, wr_stb = 0, rd_stb = 0, ifst_ld = 0;
  logic [3:0] idx_val = 0;
  logic [7:0] wdata = 0, ifst_val = 0, rdata;
  logic [31:0] hdr_bank0 = 32'h44332211, hdr_bank1 = 32'hD4C3B2A1;
  logic [31:0] stat_bytes = 32'h9E8DC37C;
  logic [7:0] if_ctrl, ctl0, ctl1;
  logic [15:0] byte_cnt, data_addr, wr_addr, blk_ptr;
  logic xfer_trig, xfer_ack, ctl_reset;
  int checks = 0, errors = 0;

  // bench model
  logic [7:0] m_ifst = 8'hFF, m_ifc = 0, m_c0 = 0, m_c1 = 0;
  logic [15:0] m_cnt = 0, m_dac = 0, m_wa = 0, m_pt = 0;

  always #2 clk = ~clk;

  ctl_regport i_ctl_regport (
    .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_val(idx_val),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata),
    .ifst_ld(ifst_ld), .ifst_val(ifst_val), .hdr_bank0(hdr_bank0),
    .hdr_bank1(hdr_bank1), .stat_bytes(stat_bytes), .if_ctrl(if_ctrl),
    .byte_cnt(byte_cnt), .data_addr(data_addr), .wr_addr(wr_addr),
    .blk_ptr(blk_ptr), .ctl0(ctl0), .ctl1(ctl1), .xfer_trig(xfer_trig),
    .xfer_ack(xfer_ack), .ctl_reset(ctl_reset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int i);
    logic [31:0] h;
    h = m_c1[0] ? hdr_bank1 : hdr_bank0;
    case (i)
      1: return m_ifst;
      2: return m_cnt[7:0];
      3: return m_cnt[15:8];
      4, 5, 6, 7: return h[(i-4)*8 +: 8];
      8: return m_pt[7:0];
      9: return m_pt[15:8];
      10: return m_wa[7:0];
      11: return m_wa[15:8];
      12: return stat_bytes[7:0];
      14: return stat_bytes[23:16];
      15: return stat_bytes[31:24];
      default: return 8'h00;
    endcase
  endfunction

  // model of a write at slot i
  task automatic model_write(input int i, input logic [7:0] v);
    case (i)
      1: m_ifc = v;
      2: m_cnt[7:0] = v;   3: m_cnt[15:8] = v;
      4: m_dac[7:0] = v;   5: m_dac[15:8] = v;
      8: m_wa[7:0] = v;    9: m_wa[15:8] = v;
      10: m_c0 = v;        11: m_c1 = v;
      12: m_pt[7:0] = v;   13: m_pt[15:8] = v;
      default: ;
    endcase
  endtask

  task automatic load_idx(input int i);
    @(negedge clk); idx_val = 4'(i); idx_ld = 1;
    @(posedge clk); #1; idx_ld = 0;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_stb = 1;
    @(posedge clk); #1; wr_stb = 0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1;
    @(posedge clk); #1; rd_stb = 0;
  endtask

  task automatic check_outputs(input string req);
    check(req, if_ctrl, m_ifc);   check(req, byte_cnt, m_cnt);
    check(req, data_addr, m_dac); check(req, wr_addr, m_wa);
    check(req, blk_ptr, m_pt);    check(req, ctl0, m_c0);
    check(req, ctl1, m_c1);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 rdata idx0", rdata, 0);
    check_outputs("R1");
    load_idx(1);
    check("R1 ifstat", rdata, 8'hFF);
    // R6 side-band status load
    @(negedge clk); ifst_val = 8'h5A; ifst_ld = 1;
    @(posedge clk); #1; ifst_ld = 0; m_ifst = 8'h5A;
    check("R6 ifstat load", rdata, 8'h5A);

    // R3/R5/R12 write sweep from slot 1 to 14
    load_idx(1);
    for (int n = 1; n <= 14; n++) begin
      logic [7:0] v;
      v = 8'(8'h10 + n * 37);
      do_write(v);
      model_write(n, v);
      check("R12 trig", xfer_trig, n == 6);
      check("R12 ack", xfer_ack, n == 7);
      check("R5", {if_ctrl, ctl0, ctl1}, {m_ifc, m_c0, m_c1});
      check("R3 next slot", rdata, exp_read(n + 1));
    end
    check_outputs("R5 sweep");
    do_write(8'h3C);            // slot 15
    check("R12 reset pulse", ctl_reset, 1);
    check("R3 wrap", rdata, 0);
    @(posedge clk); #1;
    check("R12 reset single", ctl_reset, 0);
    // R10 write at slot 0 changes nothing, read stays at 0
    do_write(8'hEE);
    check_outputs("R10 write at 0");
    check("R10 no pulse", {xfer_trig, xfer_ack, ctl_reset}, 0);
    do_read();
    check("R10 read at 0", rdata, 0);
    do_write(8'hEF);
    check_outputs("R10 index held");

    // R4/R6 read sweep
    load_idx(1);
    for (int n = 1; n <= 15; n++) begin
      check("R6 read map", rdata, exp_read(n));
      do_read();
    end
    check("R4 wrap rdata", rdata, 0);
    do_write(8'h77);
    check_outputs("R4 wrapped to 0");

    // R2 load every index
    for (int i = 0; i < 16; i++) begin
      load_idx(i);
      check("R2 load", rdata, exp_read(i));
    end

    // R8 status byte 1 hidden
    load_idx(13);
    check("R8 stat1", rdata, 0);

    // R9 header bank select
    for (int b = 0; b < 2; b++) begin
      load_idx(11);
      do_write(8'(b) | 8'h80);
      model_write(11, 8'(b) | 8'h80);
      load_idx(4);
      for (int k = 0; k < 4; k++) begin
        check("R9 header", rdata, b ? hdr_bank1[k*8 +: 8] : hdr_bank0[k*8 +: 8]);
        do_read();
      end
    end

    // R7 byte lanes
    load_idx(3); do_write(8'hAB); model_write(3, 8'hAB);
    check("R7 high only", byte_cnt, m_cnt);
    load_idx(2); do_write(8'hCD); model_write(2, 8'hCD);
    check("R7 low only", byte_cnt, m_cnt);
    load_idx(9); do_write(8'h5E); model_write(9, 8'h5E);
    check("R7 wa high", wr_addr, m_wa);

    // R11 write beats index load
    load_idx(5);
    @(negedge clk); wdata = 8'h99; wr_stb = 1; idx_val = 4'd12; idx_ld = 1;
    @(posedge clk); #1; wr_stb = 0; idx_ld = 0;
    model_write(5, 8'h99);
    check("R11 write done", data_addr, m_dac);
    check("R11 load ignored", rdata, exp_read(6));
    // R11 write beats read
    load_idx(10);
    @(negedge clk); wdata = 8'h42; wr_stb = 1; rd_stb = 1;
    @(posedge clk); #1; wr_stb = 0; rd_stb = 0;
    model_write(10, 8'h42);
    check("R11 write over read", ctl0, m_c0);
    check("R11 single step", rdata, exp_read(11));

    // R5 slot 14 stores nothing
    load_idx(14); do_write(8'hFF);
    check_outputs("R5 slot 14");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule